// File: doc/BRIEF.md
# Condition Code Branch Unit

This block carries the control state a simple processor needs for a conditional, PC-relative branch. The state is a 16-bit program counter, a three-flag condition code and a one-bit branch-enable register. An external sequencer steps it through a fetch, decode and execute cycle with a two-bit phase input. It supplies the instruction word while the cycle runs. Whenever an arithmetic, logic or memory-load result is written back, the sequencer pulses a strobe with that value.

The strobe loads the condition code from the sign of the value. Exactly one of the three flags (negative, zero, positive) is ever set.

- **Fetch** advances the PC by one.
- **Decode** recognises the branch opcode. It compares the instruction's three test bits with the condition code and records the outcome in the branch-enable register.
- **Execute** adds the sign-extended 9-bit displacement to the already-advanced PC when that register is set.

Instructions with any other opcode leave the PC alone at execute.

Top module: `cond_branch_unit`

## Requirements
- R1: After reset the PC equals the `RESET_VEC` parameter, the condition code is zero (cc_o = 3'b010) and branch_taken_o is low.
- R2: With phase 2'b01 (fetch) the PC becomes PC + 1 at the clock edge, wrapping from 16'hFFFF to 16'h0000.
- R3: When res_we_i is high the condition code becomes 3'b100 if res_val_i[15] is 1, 3'b010 if res_val_i is zero, and 3'b001 otherwise. When res_we_i is low it holds.
- R4: cc_o = {negative, zero, positive} always has exactly one bit set.
- R5: With phase 2'b10 (decode) and instr_i[15:12] = 4'b0000, the branch-enable register is set when any of instr_i[11] & cc_o[2], instr_i[10] & cc_o[1] or instr_i[9] & cc_o[0] is true, and cleared otherwise. The condition code used is the one held before that edge.
- R6: With phase 2'b11 (execute) and branch enable set, the PC becomes PC + sign-extended instr_i[8:0]. The reach is -256 to +255 relative to the already-advanced PC, and the sum wraps modulo 2^16.
- R7: With phase 2'b11 and branch enable clear, the PC is unchanged.
- R8: A test mask of 3'b111 branches whatever the condition code holds. A test mask of 3'b000 never branches.
- R9: A decode whose opcode is not 4'b0000 clears branch enable, even if the test bits match, so the following execute leaves the PC unchanged.
- R10: branch_taken_o is high exactly while the phase is execute and branch enable is set.
- R11: With phase 2'b00 (idle) the PC and branch enable hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| phase_i | input | 2 | 00 idle, 01 fetch, 10 decode, 11 execute |
| instr_i | input | 16 | Instruction word being decoded or executed |
| res_we_i | input | 1 | Result write-back strobe |
| res_val_i | input | 16 | Result value that sets the condition code |
| pc_o | output | 16 | Current program counter |
| cc_o | output | 3 | Condition code {negative, zero, positive} |
| branch_taken_o | output | 1 | High during an execute phase that loads the branch target |

## Verification
The hardest situation to reach is a stale branch enable. A branch decode sets the flag, and a later decode of another opcode, or a decode in the same cycle as a result write, must replace it before execute uses it. The stimulus reaches this with directed sequences: a matching branch decode followed directly by a non-branch decode with all test bits set, and random result strobes placed on decode cycles. These show that decode compares against the condition code held before the edge. The reset vector sits two words below the top of the address space, so both fetch and branch arithmetic cross the wrap point early in the run.

// File: rtl/cbu_pkg.sv
package cbu_pkg;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'b00,
    PH_FETCH  = 2'b01,
    PH_DECODE = 2'b10,
    PH_EXEC   = 2'b11
  } phase_e;

  localparam int CC_W = 3;
  localparam int CC_NEG = 2;
  localparam int CC_ZER = 1;
  localparam int CC_POS = 0;

  typedef logic [CC_W-1:0] cc_t;

  localparam cc_t CC_RESET = 3'b010;

endpackage

// File: rtl/cbu_rst_sync.sv
module cbu_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/cbu_cc_reg.sv
module cbu_cc_reg
  import cbu_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we_i,
  input  logic [W-1:0] val_i,
  output cc_t          cc_o
);
  cc_t cc_q;
  cc_t cc_d;
  logic is_neg;
  logic is_zero;

  always_comb begin
    is_neg  = val_i[W-1];
    is_zero = (val_i == '0);
    cc_d    = cc_q;
    if (we_i) begin
      cc_d = '0;
      if (is_neg)       cc_d[CC_NEG] = 1'b1;
      else if (is_zero) cc_d[CC_ZER] = 1'b1;
      else              cc_d[CC_POS] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cc_q <= CC_RESET;
    else        cc_q <= cc_d;
  end

  assign cc_o = cc_q;

  assert_cc_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(cc_q) == 1);

  assert_cc_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !we_i |=> $stable(cc_q));

  assert_cc_neg_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (we_i && val_i[W-1]) |=> cc_q[CC_NEG]);
endmodule

// File: rtl/cbu_br_decode.sv
module cbu_br_decode
  import cbu_pkg::*;
#(
  parameter int W     = 16,
  parameter int OPC_W = 4,
  parameter int OFF_W = 9
) (
  input  logic         clk,
  input  logic         rst_n,
  input  phase_e       phase_i,
  input  logic [W-1:0] instr_i,
  input  cc_t          cc_i,
  output logic         ben_o,
  output logic [W-1:0] off_ext_o
);
  localparam int OPC_LO  = W - OPC_W;
  localparam int MASK_LO = OFF_W;
  localparam int MASK_HI = OFF_W + CC_W - 1;
  localparam logic [OPC_W-1:0] OPC_BR = '0;

  logic [CC_W-1:0] mask;
  logic [CC_W-1:0] hit;
  logic            is_br;
  logic            ben_q;
  logic            ben_d;

  assign mask  = instr_i[MASK_HI:MASK_LO];
  assign is_br = (instr_i[W-1:OPC_LO] == OPC_BR);

  for (genvar g = 0; g < CC_W; g++) begin : g_hit
    assign hit[g] = mask[g] & cc_i[g];
  end

  assign off_ext_o = {{(W-OFF_W){instr_i[OFF_W-1]}}, instr_i[OFF_W-1:0]};

  always_comb begin
    ben_d = ben_q;
    if (phase_i == PH_DECODE) ben_d = is_br & (|hit);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ben_q <= 1'b0;
    else        ben_q <= ben_d;
  end

  assign ben_o = ben_q;

  assert_nonbr_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_i == PH_DECODE && instr_i[W-1:OPC_LO] != OPC_BR) |=> !ben_q);

  assert_mask_none_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_i == PH_DECODE && mask == '0) |=> !ben_q);

  assert_mask_all_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_i == PH_DECODE && is_br && (&mask)) |=> ben_q);

  assert_ben_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_i != PH_DECODE) |=> $stable(ben_q));
endmodule

// File: rtl/cbu_pc_reg.sv
module cbu_pc_reg
  import cbu_pkg::*;
#(
  parameter int           W         = 16,
  parameter logic [W-1:0] RESET_VEC = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  phase_e       phase_i,
  input  logic         ben_i,
  input  logic [W-1:0] off_i,
  output logic [W-1:0] pc_o
);
  logic [W-1:0] pc_q;
  logic [W-1:0] pc_d;
  logic         pc_en;

  always_comb begin
    pc_en = 1'b0;
    pc_d  = pc_q;
    unique case (phase_i)
      PH_FETCH: begin
        pc_en = 1'b1;
        pc_d  = pc_q + W'(1);
      end
      PH_EXEC: begin
        pc_en = ben_i;
        pc_d  = pc_q + off_i;
      end
      default: begin
        pc_en = 1'b0;
        pc_d  = pc_q;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     pc_q <= RESET_VEC;
    else if (pc_en) pc_q <= pc_d;
  end

  assign pc_o = pc_q;

  assert_fetch_inc_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_i == PH_FETCH) |=> (pc_q == W'($past(pc_q) + 1)));

  assert_exec_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_i == PH_EXEC && !ben_i) |=> $stable(pc_q));

  assert_idle_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_i == PH_IDLE || phase_i == PH_DECODE) |=> $stable(pc_q));
endmodule

// File: rtl/cond_branch_unit.sv
module cond_branch_unit
  import cbu_pkg::*;
#(
  parameter int           W           = 16,
  parameter int           OPC_W       = 4,
  parameter int           OFF_W       = 9,
  parameter int           SYNC_STAGES = 2,
  parameter logic [W-1:0] RESET_VEC   = 16'h3000
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [1:0]   phase_i,
  input  logic [W-1:0] instr_i,
  input  logic         res_we_i,
  input  logic [W-1:0] res_val_i,
  output logic [W-1:0] pc_o,
  output logic [2:0]   cc_o,
  output logic         branch_taken_o
);
  logic         rst_sync_n;
  phase_e       phase;
  cc_t          cc;
  logic         ben;
  logic [W-1:0] off_ext;

  assign phase = phase_e'(phase_i);

  cbu_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  cbu_cc_reg #(.W(W)) u_cc (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .we_i  (res_we_i),
    .val_i (res_val_i),
    .cc_o  (cc)
  );

  cbu_br_decode #(.W(W), .OPC_W(OPC_W), .OFF_W(OFF_W)) u_dec (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .phase_i   (phase),
    .instr_i   (instr_i),
    .cc_i      (cc),
    .ben_o     (ben),
    .off_ext_o (off_ext)
  );

  cbu_pc_reg #(.W(W), .RESET_VEC(RESET_VEC)) u_pc (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .phase_i (phase),
    .ben_i   (ben),
    .off_i   (off_ext),
    .pc_o    (pc_o)
  );

  assign cc_o           = cc;
  assign branch_taken_o = (phase == PH_EXEC) & ben;

  assert_taken_moves_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (branch_taken_o && off_ext != '0) |=> !$stable(pc_o));

  assert_taken_phase_R10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    branch_taken_o |-> (phase_i == 2'b11));
endmodule

// File: tb/cond_branch_unit_test.sv
module cond_branch_unit_test;
  localparam logic [15:0] RV = 16'hFFFE;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  phase_i = 2'b00;
  logic [15:0] instr_i = 16'h0;
  logic        res_we_i = 1'b0;
  logic [15:0] res_val_i = 16'h0;
  logic [15:0] pc_o;
  logic [2:0]  cc_o;
  logic        branch_taken_o;

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  logic [15:0] m_pc;
  logic [2:0]  m_cc;
  logic        m_ben;

  always #2 clk = ~clk;

  cond_branch_unit #(.RESET_VEC(RV)) uut (
    .clk (clk), .rst_n (rst_n), .phase_i (phase_i), .instr_i (instr_i),
    .res_we_i (res_we_i), .res_val_i (res_val_i), .pc_o (pc_o),
    .cc_o (cc_o), .branch_taken_o (branch_taken_o)
  );

  // Behavioural reference: updated on every edge from the requirement text.
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_pc <= RV; m_cc <= 3'b010; m_ben <= 1'b0;
    end else begin
      int off;
      off = int'(instr_i[8:0]);
      if (off > 255) off = off - 512;
      if (res_we_i) begin
        if (res_val_i[15]) m_cc <= 3'b100;
        else if (res_val_i == 0) m_cc <= 3'b010;
        else m_cc <= 3'b001;
      end
      case (phase_i)
        2'b01: m_pc <= m_pc + 16'd1;
        2'b10: m_ben <= (instr_i[15:12] == 4'd0) && ((instr_i[11:9] & m_cc) != 3'b000);
        2'b11: if (m_ben) m_pc <= m_pc + 16'(off);
        default: ;
      endcase
    end
  end

  task automatic check(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input logic [1:0] ph, input logic [15:0] ins,
                      input logic we, input logic [15:0] val, input string tag);
    @(negedge clk);
    phase_i = ph; instr_i = ins; res_we_i = we; res_val_i = val;
    #1;
    check(pc_o == m_pc, {tag, " pc"}, pc_o, m_pc);
    check(cc_o == m_cc, {tag, " cc"}, 16'(cc_o), 16'(m_cc));
    check(branch_taken_o == ((ph == 2'b11) && m_ben), {tag, " taken R10"},
          16'(branch_taken_o), 16'((ph == 2'b11) && m_ben));
    check($countones(cc_o) == 1, "R4 cc one-hot", 16'(cc_o), 16'h0);
  endtask

  task automatic run_instr(input logic [15:0] ins, input string tag);
    step(2'b01, ins, 1'b0, 16'h0, tag);
    step(2'b10, ins, 1'b0, 16'h0, tag);
    step(2'b11, ins, 1'b0, 16'h0, tag);
  endtask

  task automatic set_cc(input logic [15:0] v, input string tag);
    step(2'b00, 16'h0, 1'b1, v, tag);
  endtask

  initial begin
    #(4 * 150000);
    if (!finished) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog expired");
      $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) step(2'b00, 16'h0, 1'b0, 16'h0, "R1 reset state");
    check(pc_o == RV, "R1 reset pc", pc_o, RV);
    check(cc_o == 3'b010, "R1 reset cc", 16'(cc_o), 16'h2);

    // R2 wrap through FFFF -> 0000
    step(2'b01, 16'h0, 1'b0, 16'h0, "R2 fetch");
    step(2'b01, 16'h0, 1'b0, 16'h0, "R2 fetch wrap");
    step(2'b00, 16'h0, 1'b0, 16'h0, "R2 after wrap");
    check(pc_o == 16'h0000, "R2 wrapped pc", pc_o, 16'h0);

    // R3 condition code from result sign
    set_cc(16'h8000, "R3 neg");
    set_cc(16'h0000, "R3 zero");
    set_cc(16'h7FFF, "R3 pos");
    set_cc(16'hFFFF, "R3 neg all ones");
    step(2'b00, 16'h0, 1'b0, 16'h1234, "R3 no strobe hold");
    check(cc_o == 3'b100, "R3 hold", 16'(cc_o), 16'h4);

    // R6 / R5 branches with extreme offsets; PC wraps below zero
    run_instr(16'h0900, "R6 BRn -256 wrap");
    set_cc(16'h0001, "R3 pos");
    run_instr(16'h02FF, "R6 BRp +255");
    run_instr(16'h0C05, "R7 BRnz not taken");
    run_instr(16'h0000, "R8 mask none");
    set_cc(16'h0000, "R3 zero");
    run_instr(16'h0E10, "R8 mask all");
    run_instr(16'h0A03, "R7 BRnp not taken");
    run_instr(16'h0402, "R5 BRz taken");

    // R9 stale enable cleared by non-branch decode
    step(2'b01, 16'h0E07, 1'b0, 16'h0, "R9 fetch");
    step(2'b10, 16'h0E07, 1'b0, 16'h0, "R9 branch decode");
    step(2'b10, 16'h1E07, 1'b0, 16'h0, "R9 nonbranch decode");
    step(2'b11, 16'h1E07, 1'b0, 16'h0, "R9 exec");
    // R11 idle after enable set
    step(2'b10, 16'h0E07, 1'b0, 16'h0, "R11 decode");
    step(2'b00, 16'h0E07, 1'b0, 16'h0, "R11 idle");
    step(2'b11, 16'h0E07, 1'b0, 16'h0, "R11 exec after idle");
    // R5 decode uses condition code held before the edge
    set_cc(16'h0005, "R3 pos");
    step(2'b10, 16'h0201, 1'b1, 16'h8000, "R5 decode with write");
    step(2'b11, 16'h0201, 1'b0, 16'h0, "R5 exec old cc");

    // mixed random sequence
    for (int i = 0; i < 400; i++) begin
      logic [15:0] ins;
      logic [15:0] v;
      ins = 16'($urandom);
      if ($urandom_range(3) != 0) ins[15:12] = 4'd0;
      v = 16'($urandom);
      if ($urandom_range(4) == 0) v = 16'h0;
      step(2'b01, ins, 1'($urandom_range(1)), v, "R2 random fetch");
      step(2'b10, ins, 1'($urandom_range(1)), 16'($urandom), "R5 random decode");
      if ($urandom_range(5) == 0) step(2'b00, ins, 1'b0, 16'h0, "R11 random idle");
      step(2'b11, ins, 1'($urandom_range(1)), v, "R6 random exec");
    end

    finished = 1'b1;
    $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule